// File: doc/BRIEF.md
# PoE Power Budget Priority Arbiter

This block divides one shared pool of power-over-Ethernet supply among eight ports. Each port gives an enable, a two-bit priority tier and a requested power in 0.1 W units. The block computes the usable pool: it takes the available supply power, subtracts the thermal derating amount, and then subtracts a fixed reserve held by a parameter. It then visits the ports one per clock cycle in priority order. Each port receives an allocation, an action code and a reason code. When the pool runs short, the ports are degraded in a fixed ladder that depends on their tier.

A controller FSM has three states. IDLE waits for an input change. RUN settles one port per cycle. DONE publishes the results. The transitions are:
- IDLE to RUN when any input differs from the snapshot taken at the previous start, or on the first cycle after reset.
- RUN to DONE when the last pending port has been settled.
- DONE to IDLE on the next cycle.

The published allocations, actions, reasons and remaining headroom change only in the cycle that `done` is high. If an input changes during a pass, that pass still finishes on its snapshot, and a new pass follows.

Top module: `poe_budget_arbiter`

## Requirements
- R1: Usable power is avail minus derate minus the reserve (200 by default), floored at 0. At `done`, `headroom` equals usable power minus the sum of all allocations.
- R2: Ports are served in order of tier, highest first (high, then mid, then low). Within a tier they are served by ascending index, so the port with the highest index is the first to be degraded.
- R3: A port whose request fits the remaining power (for high tier, the amount left after the R7 hold) receives it in full. Its action is GRANT (1) and its reason is NONE (0).
- R4: A high-tier port (tier code 2 or 3) that does not fit is capped at the power it may take. Its action is LIMIT (2) and its reason is BUDGET_LIMIT (1). A high-tier port never gets REDUCE or SHUT.
- R5: A mid-tier port (tier code 1) that does not fit is handled in two steps:
  - If half its request (rounded down) fits, it gets that amount, with action REDUCE (3) and reason BUDGET_REDUCE (2).
  - Otherwise it gets all the remaining power, with action LIMIT (2) and reason BUDGET_LIMIT (1).
- R6: A low-tier port (tier code 0) that does not fit is handled in two steps:
  - If half its request fits, it gets REDUCE (3) with reason BUDGET_REDUCE (2).
  - Otherwise it gets 0, with action SHUT (4) and reason BUDGET_PREEMPT (3).
- R7: While a high-tier port is being served, the minimum guarantee (150 by default) is held back for every enabled high-tier port with a higher index.
- R8: A disabled port gets 0, action OFF (0) and reason NONE (0).
- R9: A change on any input, or the release of reset, starts a pass on the next clock edge. `busy` is high for N+1 cycles. `done` then pulses for one cycle, and the published outputs take their new values in that same cycle. At no other time do they change. Reset clears all outputs to 0.
- R10: Reason codes 4 (overcurrent) and 5 (overtemperature) belong to other blocks, and this block never issues them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avail_pw | input | 16 | Supply power available, 0.1 W units |
| derate_pw | input | 16 | Thermal derating amount to subtract |
| port_en | input | 8 | Per-port enable |
| port_tier | input | 16 | Two bits per port: 0 low, 1 mid, 2 or 3 high |
| port_req | input | 128 | Sixteen bits per port: requested power |
| alloc_pw | output | 128 | Sixteen bits per port: allocated power |
| port_act | output | 24 | Three bits per port: action code |
| port_why | output | 24 | Three bits per port: reason code |
| headroom | output | 16 | Pool left after the last pass |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when results are published |

## Verification
The arbiter is tested with these input patterns:
- A pool with no ports enabled.
- A pool large enough for every request.
- Progressively tighter pools that push the mid and low ports down through reduce, limit and shut.
- A derating large enough to empty the pool.

Together these patterns separate each rung of the degrade ladder. A pair of high-tier ports sharing a short pool separates the minimum-guarantee hold from a plain cap, and the same test fixes the victim order within a tier. Two low-tier ports competing for a small pool confirm the index ordering. A supply change injected in the middle of a pass confirms that the snapshot is used and that a second pass follows.

// File: rtl/poe_arb_pkg.sv
package poe_arb_pkg;

    typedef enum logic [2:0] {
        ACT_OFF    = 3'd0,
        ACT_GRANT  = 3'd1,
        ACT_LIMIT  = 3'd2,
        ACT_REDUCE = 3'd3,
        ACT_SHUT   = 3'd4
    } act_e;

    typedef enum logic [2:0] {
        WHY_NONE      = 3'd0,
        WHY_LIMIT     = 3'd1,
        WHY_REDUCE    = 3'd2,
        WHY_PREEMPT   = 3'd3,
        WHY_OVERCURR  = 3'd4,
        WHY_OVERTEMP  = 3'd5
    } why_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/poe_arb_usable.sv
module poe_arb_usable #(
    parameter int PW      = 16,
    parameter int RESERVE = 200
) (
    input  logic [PW-1:0] avail,
    input  logic [PW-1:0] derate,
    output logic [PW-1:0] usable
);
    logic [PW-1:0] net;

    always_comb begin
        net    = '0;
        usable = '0;
        if (avail > derate) begin
            net = avail - derate;
            if (net > PW'(RESERVE)) begin
                usable = net - PW'(RESERVE);
            end
        end
    end
endmodule

// File: rtl/poe_arb_pick.sv
module poe_arb_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [2*N-1:0] tier,
    input  logic [N-1:0]   pend,
    output logic [IW-1:0]  sel,
    output logic           valid
);
    int best;
    int eff;

    always_comb begin
        sel   = '0;
        valid = 1'b0;
        best  = 0;
        eff   = 0;
        for (int i = N - 1; i >= 0; i--) begin
            eff = tier[2*i+1] ? 2 : (tier[2*i] ? 1 : 0);
            if (pend[i] && (!valid || eff >= best)) begin
                valid = 1'b1;
                best  = eff;
                sel   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/poe_arb_slot.sv
module poe_arb_slot
    import poe_arb_pkg::*;
#(
    parameter int PW     = 16,
    parameter int CW     = 4,
    parameter int MIN_HI = 150
) (
    input  logic          en,
    input  logic [1:0]    tier,
    input  logic [PW-1:0] req,
    input  logic [PW-1:0] rem,
    input  logic [CW-1:0] pend_hi,
    output logic [PW-1:0] alloc,
    output act_e          act,
    output why_e          why
);
    localparam int HW = PW + CW;

    logic [HW-1:0] hold;
    logic [PW-1:0] lim_hi;
    logic [PW-1:0] half;

    always_comb begin
        hold   = HW'(pend_hi) * HW'(MIN_HI);
        lim_hi = ({{CW{1'b0}}, rem} > hold) ? (rem - hold[PW-1:0]) : '0;
        half   = req >> 1;
        alloc  = '0;
        act    = ACT_OFF;
        why    = WHY_NONE;
        if (!en) begin
            alloc = '0;
        end else if (tier[1]) begin
            if (req <= lim_hi) begin
                alloc = req;
                act   = ACT_GRANT;
            end else begin
                alloc = lim_hi;
                act   = ACT_LIMIT;
                why   = WHY_LIMIT;
            end
        end else if (req <= rem) begin
            alloc = req;
            act   = ACT_GRANT;
        end else if (half <= rem) begin
            alloc = half;
            act   = ACT_REDUCE;
            why   = WHY_REDUCE;
        end else if (tier[0]) begin
            alloc = rem;
            act   = ACT_LIMIT;
            why   = WHY_LIMIT;
        end else begin
            alloc = '0;
            act   = ACT_SHUT;
            why   = WHY_PREEMPT;
        end
    end
endmodule

// File: rtl/poe_budget_arbiter.sv
module poe_budget_arbiter
    import poe_arb_pkg::*;
#(
    parameter int N       = 8,
    parameter int PW      = 16,
    parameter int RESERVE = 200,
    parameter int MIN_HI  = 150
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   avail_pw,
    input  logic [PW-1:0]   derate_pw,
    input  logic [N-1:0]    port_en,
    input  logic [2*N-1:0]  port_tier,
    input  logic [PW*N-1:0] port_req,
    output logic [PW*N-1:0] alloc_pw,
    output logic [3*N-1:0]  port_act,
    output logic [3*N-1:0]  port_why,
    output logic [PW-1:0]   headroom,
    output logic            busy,
    output logic            done
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);

    arb_state_e st_q, st_d;

    logic [PW-1:0]   snap_avail, snap_der;
    logic [N-1:0]    snap_en;
    logic [2*N-1:0]  snap_tier;
    logic [PW*N-1:0] snap_req;
    logic            first_q;
    logic            in_diff;

    logic [PW-1:0]   rem_q;
    logic [N-1:0]    pend_q, pend_left;
    logic [PW-1:0]   usable;

    logic [IW-1:0]   sel;
    logic            sel_ok;
    logic [PW-1:0]   sel_req;
    logic [1:0]      sel_tier;
    logic            sel_en;
    logic [CW-1:0]   hi_after;

    logic [PW-1:0]   slot_alloc;
    act_e            slot_act;
    why_e            slot_why;

    logic [PW-1:0]   w_alloc [N];
    act_e            w_act   [N];
    why_e            w_why   [N];
    logic [PW-1:0]   o_alloc [N];
    act_e            o_act   [N];
    why_e            o_why   [N];
    logic [PW-1:0]   head_q;
    logic            done_q;

    assign in_diff = first_q
                   | (avail_pw  != snap_avail)
                   | (derate_pw != snap_der)
                   | (port_en   != snap_en)
                   | (port_tier != snap_tier)
                   | (port_req  != snap_req);

    poe_arb_usable #(.PW(PW), .RESERVE(RESERVE)) u_usable (
        .avail  (avail_pw),
        .derate (derate_pw),
        .usable (usable)
    );

    poe_arb_pick #(.N(N), .IW(IW)) u_pick (
        .tier  (snap_tier),
        .pend  (pend_q),
        .sel   (sel),
        .valid (sel_ok)
    );

    always_comb begin
        sel_req  = snap_req[int'(sel)*PW +: PW];
        sel_tier = snap_tier[int'(sel)*2 +: 2];
        sel_en   = snap_en[sel];
        hi_after = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_q[i] && snap_en[i] && snap_tier[2*i+1] && (IW'(i) != sel)) begin
                hi_after = hi_after + CW'(1);
            end
        end
        pend_left = pend_q & ~(N'(1) << sel);
    end

    poe_arb_slot #(.PW(PW), .CW(CW), .MIN_HI(MIN_HI)) u_slot (
        .en      (sel_en),
        .tier    (sel_tier),
        .req     (sel_req),
        .rem     (rem_q),
        .pend_hi (hi_after),
        .alloc   (slot_alloc),
        .act     (slot_act),
        .why     (slot_why)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_diff) st_d = ST_RUN;
            ST_RUN:  if (!sel_ok || pend_left == '0) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // working and published registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_avail <= '0;
            snap_der   <= '0;
            snap_en    <= '0;
            snap_tier  <= '0;
            snap_req   <= '0;
            first_q    <= 1'b1;
            rem_q      <= '0;
            pend_q     <= '0;
            head_q     <= '0;
            done_q     <= 1'b0;
            for (int i = 0; i < N; i++) begin
                w_alloc[i] <= '0;
                w_act[i]   <= ACT_OFF;
                w_why[i]   <= WHY_NONE;
                o_alloc[i] <= '0;
                o_act[i]   <= ACT_OFF;
                o_why[i]   <= WHY_NONE;
            end
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (in_diff) begin
                        snap_avail <= avail_pw;
                        snap_der   <= derate_pw;
                        snap_en    <= port_en;
                        snap_tier  <= port_tier;
                        snap_req   <= port_req;
                        first_q    <= 1'b0;
                        rem_q      <= usable;
                        pend_q     <= '1;
                    end
                end
                ST_RUN: begin
                    if (sel_ok) begin
                        w_alloc[sel] <= slot_alloc;
                        w_act[sel]   <= slot_act;
                        w_why[sel]   <= slot_why;
                        rem_q        <= rem_q - slot_alloc;
                        pend_q       <= pend_left;
                    end
                end
                ST_DONE: begin
                    for (int i = 0; i < N; i++) begin
                        o_alloc[i] <= w_alloc[i];
                        o_act[i]   <= w_act[i];
                        o_why[i]   <= w_why[i];
                    end
                    head_q <= rem_q;
                    done_q <= 1'b1;
                end
                default: done_q <= 1'b0;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign headroom = head_q;

    for (genvar g = 0; g < N; g++) begin : g_out
        assign alloc_pw[g*PW +: PW] = o_alloc[g];
        assign port_act[g*3 +: 3]   = o_act[g];
        assign port_why[g*3 +: 3]   = o_why[g];
    end
endmodule

// File: rtl/poe_budget_arbiter_chk.sv
module poe_budget_arbiter_chk #(
    parameter int N  = 8,
    parameter int PW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PW*N-1:0] alloc_pw,
    input logic [3*N-1:0]  port_act,
    input logic [3*N-1:0]  port_why,
    input logic [PW-1:0]   headroom,
    input logic            busy,
    input logic            done
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= (busy_run > N + 2) ? busy_run : busy_run + 1;
        else           busy_run <= 0;
    end

    // R9: a pass never outlasts N+1 cycles
    p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= N + 1);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({alloc_pw, port_act, port_why, headroom}) |-> done);

    for (genvar g = 0; g < N; g++) begin : g_port
        p_no_fault_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (port_why[g*3 +: 3] != 3'd4) && (port_why[g*3 +: 3] != 3'd5));

        p_shut_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (port_act[g*3 +: 3] == 3'd4) |-> (alloc_pw[g*PW +: PW] == '0 && port_why[g*3 +: 3] == 3'd3));

        p_grant_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (port_act[g*3 +: 3] == 3'd1) |-> (port_why[g*3 +: 3] == 3'd0));

        p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (port_act[g*3 +: 3] == 3'd0) |-> (alloc_pw[g*PW +: PW] == '0 && port_why[g*3 +: 3] == 3'd0));
    end
endmodule

bind poe_budget_arbiter poe_budget_arbiter_chk #(.N(N), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_pw (alloc_pw),
    .port_act (port_act),
    .port_why (port_why),
    .headroom (headroom),
    .busy     (busy),
    .done     (done)
);

// File: tb/poe_budget_arbiter_bench.sv
module poe_budget_arbiter_bench;
    localparam int N    = 8;
    localparam int PW   = 16;
    localparam int RES  = 200;
    localparam int MINH = 150;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [PW-1:0]   avail, derate;
    logic [N-1:0]    en;
    logic [2*N-1:0]  tier;
    logic [PW*N-1:0] req;
    logic [PW*N-1:0] alloc_pw;
    logic [3*N-1:0]  port_act, port_why;
    logic [PW-1:0]   headroom;
    logic            busy, done;

    poe_budget_arbiter #(.N(N), .PW(PW), .RESERVE(RES), .MIN_HI(MINH)) u_poe_budget_arbiter (
        .clk(clk), .rst_n(rst_n), .avail_pw(avail), .derate_pw(derate),
        .port_en(en), .port_tier(tier), .port_req(req),
        .alloc_pw(alloc_pw), .port_act(port_act), .port_why(port_why),
        .headroom(headroom), .busy(busy), .done(done)
    );

    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;
    string cur_tag = "R9";

    // reference model state
    int m_cnt = 0;
    bit m_first = 1;
    bit m_done = 0;
    int m_head = 0, p_head = 0;
    int m_alloc[N], m_act[N], m_why[N];
    int p_alloc[N], p_act[N], p_why[N];
    logic [PW-1:0]   s_av = '0, s_de = '0;
    logic [N-1:0]    s_en = '0;
    logic [2*N-1:0]  s_ti = '0;
    logic [PW*N-1:0] s_rq = '0;

    task automatic chk(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic model_eval();
        int d, rem;
        d   = int'(avail) - int'(derate) - RES;
        rem = (d < 0) ? 0 : d;
        for (int t = 2; t >= 0; t--) begin
            for (int i = 0; i < N; i++) begin
                int tc, r, h, lim, pend;
                tc = int'(tier[2*i +: 2]);
                if (tc > 2) tc = 2;
                if (tc != t) continue;
                r = int'(req[PW*i +: PW]);
                h = r / 2;
                if (!en[i]) begin
                    p_alloc[i] = 0; p_act[i] = 0; p_why[i] = 0;
                    continue;
                end
                if (t == 2) begin
                    pend = 0;
                    for (int j = i + 1; j < N; j++) if (en[j] && tier[2*j+1]) pend++;
                    lim = rem - pend * MINH;
                    if (lim < 0) lim = 0;
                    if (r <= lim) begin p_alloc[i] = r;   p_act[i] = 1; p_why[i] = 0; end
                    else          begin p_alloc[i] = lim; p_act[i] = 2; p_why[i] = 1; end
                end else if (r <= rem) begin
                    p_alloc[i] = r; p_act[i] = 1; p_why[i] = 0;
                end else if (h <= rem) begin
                    p_alloc[i] = h; p_act[i] = 3; p_why[i] = 2;
                end else if (t == 1) begin
                    p_alloc[i] = rem; p_act[i] = 2; p_why[i] = 1;
                end else begin
                    p_alloc[i] = 0; p_act[i] = 4; p_why[i] = 3;
                end
                rem = rem - p_alloc[i];
            end
        end
        p_head = rem;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_first = 1; m_done = 0; m_head = 0;
            for (int i = 0; i < N; i++) begin m_alloc[i] = 0; m_act[i] = 0; m_why[i] = 0; end
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    for (int i = 0; i < N; i++) begin
                        m_alloc[i] = p_alloc[i]; m_act[i] = p_act[i]; m_why[i] = p_why[i];
                    end
                    m_head = p_head;
                    m_done = 1;
                end
            end else if (m_first || avail != s_av || derate != s_de || en != s_en
                         || tier != s_ti || req != s_rq) begin
                m_first = 0;
                s_av = avail; s_de = derate; s_en = en; s_ti = tier; s_rq = req;
                model_eval();
                m_cnt = N + 1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9", "busy", int'(busy), (m_cnt > 0) ? 1 : 0);
            chk("R9", "done", int'(done), int'(m_done));
            chk(cur_tag, "headroom", int'(headroom), m_head);
            for (int i = 0; i < N; i++) begin
                chk(cur_tag, $sformatf("alloc[%0d]", i), int'(alloc_pw[PW*i +: PW]), m_alloc[i]);
                chk(cur_tag, $sformatf("act[%0d]", i), int'(port_act[3*i +: 3]), m_act[i]);
                chk(cur_tag, $sformatf("why[%0d]", i), int'(port_why[3*i +: 3]), m_why[i]);
                chk("R10", $sformatf("why_legal[%0d]", i),
                    (port_why[3*i +: 3] == 3'd4 || port_why[3*i +: 3] == 3'd5) ? 1 : 0, 0);
            end
        end
    end

    task automatic setp(int i, bit e, int t, int r);
        en[i] = e;
        tier[2*i +: 2] = 2'(t);
        req[PW*i +: PW] = PW'(r);
    endtask

    task automatic wait_done(string tag);
        int k;
        k = 0;
        @(negedge clk);
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(tag, "done_seen", int'(done), 1);
    endtask

    task automatic port_is(string tag, int i, int a, int act, int why);
        chk(tag, $sformatf("spot alloc[%0d]", i), int'(alloc_pw[PW*i +: PW]), a);
        chk(tag, $sformatf("spot act[%0d]", i), int'(port_act[3*i +: 3]), act);
        chk(tag, $sformatf("spot why[%0d]", i), int'(port_why[3*i +: 3]), why);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog got=hung exp=finished");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        avail = 16'd1000; derate = '0; en = '0; tier = '0; req = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset busy", int'(busy), 0);
        chk("R9", "reset done", int'(done), 0);
        chk("R9", "reset headroom", int'(headroom), 0);
        chk("R9", "reset alloc", (alloc_pw == '0) ? 1 : 0, 1);
        rst_n = 1'b1;

        // R8 / R1: nothing enabled, usable 800
        cur_tag = "R8";
        wait_done("R8");
        chk("R1", "headroom empty", int'(headroom), 800);
        port_is("R8", 0, 0, 0, 0);

        // R3: everything fits
        cur_tag = "R3";
        setp(0, 1, 2, 300); setp(1, 1, 1, 200); setp(2, 1, 0, 100);
        wait_done("R3");
        port_is("R3", 0, 300, 1, 0);
        port_is("R3", 1, 200, 1, 0);
        port_is("R3", 2, 100, 1, 0);
        chk("R1", "headroom fit", int'(headroom), 200);
        repeat (3) @(negedge clk);
        chk("R9", "idle after settle", int'(busy), 0);

        // R6: low port shut (preempt)
        cur_tag = "R6";
        avail = 16'd700;
        wait_done("R6");
        port_is("R6", 2, 0, 4, 3);
        port_is("R3", 1, 200, 1, 0);

        // R5: mid port limited after reduce fails
        cur_tag = "R5";
        setp(0, 1, 2, 450);
        wait_done("R5");
        port_is("R5", 1, 50, 2, 1);
        port_is("R6", 2, 0, 4, 3);

        // R5 / R6 reduce rung
        cur_tag = "R5";
        setp(0, 1, 2, 350);
        wait_done("R5");
        port_is("R5", 1, 100, 3, 2);
        port_is("R6", 2, 50, 3, 2);
        chk("R1", "headroom reduce", int'(headroom), 0);

        // R1 / R4: derating empties the pool
        cur_tag = "R4";
        derate = 16'd600;
        wait_done("R4");
        port_is("R4", 0, 0, 2, 1);
        port_is("R5", 1, 0, 2, 1);
        chk("R1", "headroom derated", int'(headroom), 0);

        // R7 / R2: two high ports, minimum hold, tier code 3
        cur_tag = "R7";
        derate = '0;
        setp(0, 0, 2, 0); setp(1, 0, 1, 0); setp(2, 0, 0, 0);
        setp(3, 1, 2, 400); setp(5, 1, 3, 400);
        wait_done("R7");
        port_is("R7", 3, 350, 2, 1);
        port_is("R2", 5, 150, 2, 1);

        // R2: equal low tier, highest index loses
        cur_tag = "R2";
        setp(5, 0, 3, 400); setp(6, 1, 0, 100); setp(7, 1, 0, 100);
        wait_done("R2");
        port_is("R3", 3, 400, 1, 0);
        port_is("R2", 6, 100, 1, 0);
        port_is("R2", 7, 0, 4, 3);

        // R9: change in the middle of a pass triggers a second pass
        cur_tag = "R9";
        avail = 16'd900;
        repeat (3) @(negedge clk);
        avail = 16'd850;
        wait_done("R9");
        chk("R9", "first pass headroom", int'(headroom), 100);
        wait_done("R9");
        chk("R9", "second pass headroom", int'(headroom), 50);
        port_is("R3", 7, 100, 1, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule